// File: doc/BRIEF.md
# Two-Stage Watchdog Timer Register Block

This block is a watchdog with a small register file. A down-counter runs from a programmable initial value and moves one step on each strobe from an external tick prescaler. When the count runs out for the first time, the block sets a timeout flag and raises a management interrupt. That interrupt is either the system-management interrupt or the non-maskable interrupt, and the SMI-enable input chooses which. The counter then reloads and keeps running.

If the count runs out a second time with no reload write in between, the block sets two flags in the second status word. It then asks for a system reset, unless either of two inhibit inputs is high. When a reset is requested, the counter stops.

Software reaches the register file through a plain register port. Each access uses a register index, a write strobe and two byte enables. Read data is combinational and reads have no side effects. Besides the timer, the file holds:
- two mailbox bytes, whose writes raise status flags;
- two message bytes;
- a watchdog-count byte;
- a software-interrupt byte;
- two control words, one of them holding a lock bit that stays set once written.

Top module: `wdog2_regs`

## Requirements
- R1: After reset, the registers read as follows: initial value 4, control word 2 0x0008, software-IRQ byte 0x03, every other register 0. The counter is not running and no pulse output is high.
- R2: The counter runs only when the halt bit (control word 1, bit 11) is clear and the initial value is greater than 1. With an initial value of 0 or 1, ticks never produce an expiry.
- R3: A running counter loaded with N expires on the Nth tick strobe. On expiry:
  - status word 1 bit 3 is set;
  - the count reloads to N;
  - a one-cycle pulse appears on smi_o when smi_en_i was high at that tick, and on nmi_o otherwise.
- R4: The block counts consecutive expiries. On the second one, status word 2 bits 1 and 2 are set and the count returns to zero, so the next expiry is a first one again.
- R5: On a second expiry with both strap_inh_i and noreboot_i low, the block does the following:
  - it gives a one-cycle pulse on sysrst_o;
  - it raises neither smi_o nor nmi_o;
  - the counter stops;
  - the reload register reads 0.

  If either inhibit input is high, the second expiry raises an interrupt as in R3.
- R6: A write to the reload register clears the consecutive-expiry count. If the run conditions hold, the counter restarts from the initial value. Otherwise the written value is stored and reads back.
- R7: While the counter runs, a read of the reload register returns the remaining tick count. That count is N minus the ticks seen since the last load.
- R8: Control word 1 bit 12 is a lock. Once it is set, no write can clear it; only reset clears it.
- R9: A write to control word 1 is handled as follows:
  - it stores only bits 11 and 12;
  - it starts and reloads the counter when the run conditions hold with the new value;
  - it stops the counter otherwise.
- R10: A write to the data-in register (index 2) does three things: it stores the byte, sets status word 1 bit 1, and pulses smi_o. A write to the data-out register (index 3) stores the byte and sets status word 1 bit 2, with no pulse.
- R11: Writes to the status words store only the implemented bits. For status word 1 the mask is 0x000E; for status word 2 it is 0x0006.
- R12: The register indices are:

  | Index | Register | Width |
  |---|---|---|
  | 0 | reload | 16 bits |
  | 1 | initial value | 10 bits |
  | 2 | data-in | 8 bits |
  | 3 | data-out | 8 bits |
  | 4 | status word 1 | 16 bits |
  | 5 | status word 2 | 16 bits |
  | 6 | control word 1 | 16 bits |
  | 7 | control word 2 | 16 bits |
  | 8 | message 1 | 8 bits |
  | 9 | message 2 | 8 bits |
  | 10 | watchdog count | 8 bits |
  | 11 | software IRQ | 8 bits |

  Byte enable bit 0 writes data bits 7:0 and bit 1 writes bits 15:8. Unimplemented upper bits read 0.
- R13: smi_o, nmi_o and sysrst_o are single-cycle pulses, and sysrst_o never coincides with nmi_o. Reads change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | One-cycle strobe from the tick prescaler |
| smi_en_i | input | 1 | Selects SMI (1) or NMI (0) on expiry |
| strap_inh_i | input | 1 | Strap-level reset inhibit |
| noreboot_i | input | 1 | Configuration-level reset inhibit |
| reg_addr_i | input | 4 | Register index |
| reg_wr_i | input | 1 | Write strobe |
| reg_be_i | input | 2 | Byte enables for the write |
| reg_wdata_i | input | 16 | Write data |
| reg_rdata_o | output | 16 | Read data of the indexed register |
| smi_o | output | 1 | System-management interrupt pulse |
| nmi_o | output | 1 | Non-maskable interrupt pulse |
| sysrst_o | output | 1 | System reset request pulse |

## Verification
The hardest case to reach from the ports is a second expiry that must be told apart from a first. A reload write has to clear the consecutive-expiry count even while the counter is already running. The stimulus drives the timer through one expiry, writes the reload register, and then counts the ticks exactly. It checks that the next expiry gives only an interrupt and that the one after it gives the reset request.

The bench sweeps initial values 0 to 6. It alternates the SMI-enable input and which inhibit input is high. For every tick it compares the live count against the initial value minus the ticks applied.

// File: rtl/wdog2_pkg.sv
package wdog2_pkg;
    localparam int REG_AW = 4;
    localparam int REG_DW = 16;

    typedef enum logic [REG_AW-1:0] {
        A_RELOAD = 4'd0,
        A_INIT   = 4'd1,
        A_DIN    = 4'd2,
        A_DOUT   = 4'd3,
        A_STAT1  = 4'd4,
        A_STAT2  = 4'd5,
        A_CTRL1  = 4'd6,
        A_CTRL2  = 4'd7,
        A_MSG1   = 4'd8,
        A_MSG2   = 4'd9,
        A_WDCNT  = 4'd10,
        A_SWIRQ  = 4'd11
    } reg_addr_e;

    localparam logic [REG_DW-1:0] ST1_MASK   = 16'h000E;
    localparam logic [REG_DW-1:0] ST2_MASK   = 16'h0006;
    localparam logic [REG_DW-1:0] C1_MASK    = 16'h1800;
    localparam logic [REG_DW-1:0] ST1_SWSMI  = 16'h0002;
    localparam logic [REG_DW-1:0] ST1_INTF   = 16'h0004;
    localparam logic [REG_DW-1:0] ST1_TOUT   = 16'h0008;
    localparam logic [REG_DW-1:0] ST2_SECBOOT = 16'h0006;
    localparam int C1_HALT_BIT = 11;
    localparam int C1_LOCK_BIT = 12;
    localparam logic [REG_DW-1:0] C2_RST_VAL = 16'h0008;
    localparam logic [7:0]        SWI_RST_VAL = 8'h03;
    localparam int INIT_RST_VAL = 4;
endpackage

// File: rtl/wdog2_wmerge.sv
module wdog2_wmerge #(
    parameter int DW = 16
) (
    input  logic [DW-1:0]   old_i,
    input  logic [DW-1:0]   wdata_i,
    input  logic [DW/8-1:0] be_i,
    output logic [DW-1:0]   merged_o
);
    localparam int NB = DW / 8;

    for (genvar b = 0; b < NB; b++) begin : g_byte
        assign merged_o[8*b +: 8] = be_i[b] ? wdata_i[8*b +: 8] : old_i[8*b +: 8];
    end
endmodule

// File: rtl/wdog2_rdmux.sv
module wdog2_rdmux
    import wdog2_pkg::*;
#(
    parameter int CNT_W = 10
) (
    input  logic [REG_AW-1:0] addr_i,
    input  logic [REG_DW-1:0] rld_view_i,
    input  logic [CNT_W-1:0]  init_i,
    input  logic [7:0]        din_i,
    input  logic [7:0]        dout_i,
    input  logic [REG_DW-1:0] st1_i,
    input  logic [REG_DW-1:0] st2_i,
    input  logic [REG_DW-1:0] c1_i,
    input  logic [REG_DW-1:0] c2_i,
    input  logic [7:0]        m1_i,
    input  logic [7:0]        m2_i,
    input  logic [7:0]        wdc_i,
    input  logic [7:0]        swi_i,
    output logic [REG_DW-1:0] rdata_o
);
    always_comb begin
        rdata_o = '0;
        case (addr_i)
            A_RELOAD: rdata_o = rld_view_i;
            A_INIT:   rdata_o = REG_DW'(init_i);
            A_DIN:    rdata_o = {8'h00, din_i};
            A_DOUT:   rdata_o = {8'h00, dout_i};
            A_STAT1:  rdata_o = st1_i;
            A_STAT2:  rdata_o = st2_i;
            A_CTRL1:  rdata_o = c1_i;
            A_CTRL2:  rdata_o = c2_i;
            A_MSG1:   rdata_o = {8'h00, m1_i};
            A_MSG2:   rdata_o = {8'h00, m2_i};
            A_WDCNT:  rdata_o = {8'h00, wdc_i};
            A_SWIRQ:  rdata_o = {8'h00, swi_i};
            default:  rdata_o = '0;
        endcase
    end
endmodule

// File: rtl/wdog2_regs.sv
module wdog2_regs
    import wdog2_pkg::*;
#(
    parameter int CNT_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              smi_en_i,
    input  logic              strap_inh_i,
    input  logic              noreboot_i,
    input  logic [REG_AW-1:0] reg_addr_i,
    input  logic              reg_wr_i,
    input  logic [1:0]        reg_be_i,
    input  logic [REG_DW-1:0] reg_wdata_i,
    output logic [REG_DW-1:0] reg_rdata_o,
    output logic              smi_o,
    output logic              nmi_o,
    output logic              sysrst_o
);
    localparam int TOS_W = 2;
    localparam logic [TOS_W-1:0] TOS_LIMIT = TOS_W'(2);

    typedef struct packed {
        logic [REG_DW-1:0] rld;
        logic [CNT_W-1:0]  init;
        logic [7:0]        din;
        logic [7:0]        dout;
        logic [REG_DW-1:0] st1;
        logic [REG_DW-1:0] st2;
        logic [REG_DW-1:0] c1;
        logic [REG_DW-1:0] c2;
        logic [7:0]        m1;
        logic [7:0]        m2;
        logic [7:0]        wdc;
        logic [7:0]        swi;
        logic [CNT_W-1:0]  cnt;
        logic              run;
        logic [TOS_W-1:0]  tos;
        logic              smi;
        logic              nmi;
        logic              rst;
    } state_t;

    state_t st_q, st_d;

    logic [REG_DW-1:0] rld_view;
    logic [REG_DW-1:0] rdata;
    logic [REG_DW-1:0] old_val;
    logic [REG_DW-1:0] wval;
    logic [REG_DW-1:0] c1_new;
    logic [TOS_W-1:0]  tos_n;
    logic              can_run_now;
    logic              can_run_c1;

    assign rld_view = st_q.run ? REG_DW'(st_q.cnt) : st_q.rld;

    wdog2_rdmux #(.CNT_W(CNT_W)) u_rdmux (
        .addr_i     (reg_addr_i),
        .rld_view_i (rld_view),
        .init_i     (st_q.init),
        .din_i      (st_q.din),
        .dout_i     (st_q.dout),
        .st1_i      (st_q.st1),
        .st2_i      (st_q.st2),
        .c1_i       (st_q.c1),
        .c2_i       (st_q.c2),
        .m1_i       (st_q.m1),
        .m2_i       (st_q.m2),
        .wdc_i      (st_q.wdc),
        .swi_i      (st_q.swi),
        .rdata_o    (rdata)
    );

    assign reg_rdata_o = rdata;
    assign old_val     = (reg_addr_i == A_RELOAD) ? st_q.rld : rdata;

    wdog2_wmerge #(.DW(REG_DW)) u_wmerge (
        .old_i    (old_val),
        .wdata_i  (reg_wdata_i),
        .be_i     (reg_be_i),
        .merged_o (wval)
    );

    assign c1_new      = (wval & C1_MASK) | (st_q.c1 & (REG_DW'(1) << C1_LOCK_BIT));
    assign can_run_now = !st_q.c1[C1_HALT_BIT] && (st_q.init > CNT_W'(1));
    assign can_run_c1  = !c1_new[C1_HALT_BIT] && (st_q.init > CNT_W'(1));
    assign tos_n       = st_q.tos + TOS_W'(1);

    always_comb begin
        st_d     = st_q;
        st_d.smi = 1'b0;
        st_d.nmi = 1'b0;
        st_d.rst = 1'b0;

        // countdown and two-stage expiry
        if (tick_i && st_q.run) begin
            if (st_q.cnt <= CNT_W'(1)) begin
                st_d.st1 = st_q.st1 | ST1_TOUT;
                st_d.tos = tos_n;
                st_d.cnt = st_q.init;
                st_d.rld = REG_DW'(st_q.init);
                if (tos_n == TOS_LIMIT) begin
                    st_d.st2 = st_q.st2 | ST2_SECBOOT;
                    st_d.tos = '0;
                end
                if (tos_n == TOS_LIMIT && !strap_inh_i && !noreboot_i) begin
                    st_d.rst = 1'b1;
                    st_d.run = 1'b0;
                    st_d.rld = '0;
                end else if (smi_en_i) begin
                    st_d.smi = 1'b1;
                end else begin
                    st_d.nmi = 1'b1;
                end
            end else begin
                st_d.cnt = st_q.cnt - CNT_W'(1);
            end
        end

        // register writes take precedence over same-cycle timer updates
        if (reg_wr_i) begin
            case (reg_addr_i)
                A_RELOAD: begin
                    st_d.tos = '0;
                    if (can_run_now) begin
                        st_d.rld = REG_DW'(st_q.init);
                        st_d.cnt = st_q.init;
                        st_d.run = 1'b1;
                    end else begin
                        st_d.rld = wval;
                    end
                end
                A_INIT:  st_d.init = wval[CNT_W-1:0];
                A_DIN: begin
                    st_d.din = wval[7:0];
                    st_d.st1 = st_d.st1 | ST1_SWSMI;
                    st_d.smi = 1'b1;
                end
                A_DOUT: begin
                    st_d.dout = wval[7:0];
                    st_d.st1  = st_d.st1 | ST1_INTF;
                end
                A_STAT1: st_d.st1 = wval & ST1_MASK;
                A_STAT2: st_d.st2 = wval & ST2_MASK;
                A_CTRL1: begin
                    st_d.c1 = c1_new;
                    if (can_run_c1) begin
                        st_d.rld = REG_DW'(st_q.init);
                        st_d.cnt = st_q.init;
                        st_d.run = 1'b1;
                    end else begin
                        st_d.run = 1'b0;
                    end
                end
                A_CTRL2: st_d.c2  = wval;
                A_MSG1:  st_d.m1  = wval[7:0];
                A_MSG2:  st_d.m2  = wval[7:0];
                A_WDCNT: st_d.wdc = wval[7:0];
                A_SWIRQ: st_d.swi = wval[7:0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.init <= CNT_W'(INIT_RST_VAL);
            st_q.c2   <= C2_RST_VAL;
            st_q.swi  <= SWI_RST_VAL;
        end else begin
            st_q <= st_d;
        end
    end

    assign smi_o    = st_q.smi;
    assign nmi_o    = st_q.nmi;
    assign sysrst_o = st_q.rst;
endmodule

// File: rtl/wdog2_regs_chk.sv
module wdog2_regs_chk (
    input logic clk,
    input logic rst_n,
    input logic smi_en_i,
    input logic nmi_o,
    input logic sysrst_o,
    input logic run,
    input logic lock,
    input logic halt
);
    // R13: reset request and NMI never share a cycle
    assert_rst_nmi_excl_R13: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({sysrst_o, nmi_o}));

    // R13: reset request is a single-cycle pulse
    assert_rst_single_R13: assert property (@(posedge clk) disable iff (!rst_n)
        sysrst_o |=> !sysrst_o);

    // R3: NMI only when SMI was not enabled at the expiring tick
    assert_nmi_sel_R3: assert property (@(posedge clk) disable iff (!rst_n)
        nmi_o |-> !$past(smi_en_i));

    // R5: a reset request leaves the counter stopped
    assert_rst_stops_R5: assert property (@(posedge clk) disable iff (!rst_n)
        sysrst_o |-> !run);

    // R8: the lock bit never falls outside reset
    assert_lock_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(lock) |-> lock);

    // R2: a set halt bit means the counter is idle
    assert_halt_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        halt |-> !run);
endmodule

bind wdog2_regs wdog2_regs_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .smi_en_i (smi_en_i),
    .nmi_o    (nmi_o),
    .sysrst_o (sysrst_o),
    .run      (st_q.run),
    .lock     (st_q.c1[12]),
    .halt     (st_q.c1[11])
);

// File: tb/wdog2_regs_bench.sv
module wdog2_regs_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_i = 1'b0;
    logic        smi_en_i = 1'b0;
    logic        strap_inh_i = 1'b0;
    logic        noreboot_i = 1'b0;
    logic [3:0]  reg_addr_i = '0;
    logic        reg_wr_i = 1'b0;
    logic [1:0]  reg_be_i = 2'b11;
    logic [15:0] reg_wdata_i = '0;
    logic [15:0] reg_rdata_o;
    logic        smi_o, nmi_o, sysrst_o;

    int checks = 0;
    int fails  = 0;
    logic p_smi, p_nmi, p_rst;
    logic [15:0] rv;

    always #4 clk = ~clk;

    wdog2_regs u_wdog2_regs (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .smi_en_i(smi_en_i),
        .strap_inh_i(strap_inh_i), .noreboot_i(noreboot_i),
        .reg_addr_i(reg_addr_i), .reg_wr_i(reg_wr_i), .reg_be_i(reg_be_i),
        .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o),
        .smi_o(smi_o), .nmi_o(nmi_o), .sysrst_o(sysrst_o)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic chk_pulses(input string req, input logic s, input logic n, input logic r);
        chk(req, {13'd0, p_smi, p_nmi, p_rst}, {13'd0, s, n, r});
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); @(negedge clk); rst_n = 1'b1;
    endtask

    task automatic wr(input logic [3:0] a, input logic [15:0] d, input logic [1:0] be);
        @(negedge clk);
        reg_addr_i = a; reg_wdata_i = d; reg_be_i = be; reg_wr_i = 1'b1;
        @(negedge clk);
        reg_wr_i = 1'b0;
        p_smi = smi_o; p_nmi = nmi_o; p_rst = sysrst_o;
    endtask

    task automatic rd(input logic [3:0] a, output logic [15:0] v);
        reg_addr_i = a;
        #1 v = reg_rdata_o;
    endtask

    task automatic tk();
        @(negedge clk); tick_i = 1'b1;
        @(negedge clk); tick_i = 1'b0;
        p_smi = smi_o; p_nmi = nmi_o; p_rst = sysrst_o;
    endtask

    // watchdog for a hung run
    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [15:0] exp_rst [12];
        exp_rst = '{16'h0, 16'h4, 16'h0, 16'h0, 16'h0, 16'h0, 16'h0, 16'h8,
                    16'h0, 16'h0, 16'h0, 16'h3};
        do_reset();

        // R1 reset values
        for (int a = 0; a < 12; a++) begin
            rd(4'(a), rv);
            chk("R1 reset value", rv, exp_rst[a]);
        end
        chk("R1 no pulse", {13'd0, smi_o, nmi_o, sysrst_o}, 16'd0);
        // R2: counter idle until control word 1 written
        for (int k = 0; k < 6; k++) begin
            tk();
            chk_pulses("R2 idle after reset", 0, 0, 0);
        end

        // Sweep initial values; R2 R3 R4 R7
        for (int n = 0; n <= 6; n++) begin
            smi_en_i    = n[0];
            strap_inh_i = ~n[0];
            noreboot_i  = n[0];
            wr(4'd1, 16'(n), 2'b11);
            wr(4'd6, 16'h0000, 2'b11);
            if (n <= 1) begin
                for (int k = 0; k < 8; k++) begin
                    tk();
                    chk_pulses("R2 init 0/1 never expires", 0, 0, 0);
                end
            end else begin
                for (int stage = 0; stage < 2; stage++) begin
                    for (int k = 1; k < n; k++) begin
                        tk();
                        chk_pulses("R3 no early expiry", 0, 0, 0);
                        rd(4'd0, rv);
                        chk("R7 live count", rv, 16'(n - k));
                    end
                    tk();
                    chk_pulses("R3 expiry pulse", n[0], ~n[0], 0);
                    rd(4'd0, rv);
                    chk("R3 reload after expiry", rv, 16'(n));
                    rd(4'd4, rv);
                    chk("R3 timeout flag", rv & 16'h0008, 16'h0008);
                    rd(4'd5, rv);
                    chk("R4 second-expiry flags", rv, (stage == 1) ? 16'h0006 : 16'h0000);
                end
            end
            wr(4'd4, 16'h0, 2'b11);
            wr(4'd5, 16'h0, 2'b11);
            wr(4'd6, 16'h0800, 2'b11);
            tk();
            chk_pulses("R9 halt stops", 0, 0, 0);
        end

        // R5: reset on second expiry
        smi_en_i = 0; strap_inh_i = 0; noreboot_i = 0;
        wr(4'd1, 16'd3, 2'b11);
        wr(4'd6, 16'h0000, 2'b11);
        repeat (3) tk();
        chk_pulses("R5 first expiry nmi", 0, 1, 0);
        repeat (2) tk();
        tk();
        chk_pulses("R5 second expiry reset only", 0, 0, 1);
        @(negedge clk);
        chk("R13 reset pulse width", {15'd0, sysrst_o}, 16'd0);
        rd(4'd0, rv);
        chk("R5 reload reads 0", rv, 16'd0);
        for (int k = 0; k < 5; k++) begin
            tk();
            chk_pulses("R5 counter stopped", 0, 0, 0);
        end

        // R6: reload write clears consecutive count
        wr(4'd1, 16'd4, 2'b11);
        wr(4'd6, 16'h0000, 2'b11);
        repeat (4) tk();
        chk_pulses("R6 first expiry", 0, 1, 0);
        repeat (2) tk();
        wr(4'd0, 16'hBEEF, 2'b11);
        rd(4'd0, rv);
        chk("R6 restart from init", rv, 16'd4);
        repeat (4) tk();
        chk_pulses("R6 count cleared: interrupt not reset", 0, 1, 0);
        repeat (4) tk();
        chk_pulses("R6 then reset", 0, 0, 1);
        wr(4'd6, 16'h0800, 2'b11);
        wr(4'd0, 16'h1234, 2'b11);
        rd(4'd0, rv);
        chk("R6 stored when halted", rv, 16'h1234);
        // R12 byte enable on reload store
        wr(4'd0, 16'hAB00, 2'b10);
        rd(4'd0, rv);
        chk("R12 upper byte write", rv, 16'hAB34);

        // R10 mailboxes
        wr(4'd4, 16'h0, 2'b11);
        wr(4'd2, 16'h005A, 2'b11);
        chk_pulses("R10 data-in smi", 1, 0, 0);
        @(negedge clk);
        chk("R13 smi pulse width", {15'd0, smi_o}, 16'd0);
        rd(4'd4, rv);
        chk("R10 sw-smi flag", rv, 16'h0002);
        rd(4'd2, rv);
        chk("R10 data-in value", rv, 16'h005A);
        wr(4'd3, 16'hFFA5, 2'b11);
        chk_pulses("R10 data-out no pulse", 0, 0, 0);
        rd(4'd4, rv);
        chk("R10 int flag", rv, 16'h0006);
        rd(4'd3, rv);
        chk("R12 8-bit register", rv, 16'h00A5);

        // R11 status masks
        wr(4'd4, 16'hFFFF, 2'b11);
        rd(4'd4, rv);
        chk("R11 status1 mask", rv, 16'h000E);
        wr(4'd5, 16'hFFFF, 2'b11);
        rd(4'd5, rv);
        chk("R11 status2 mask", rv, 16'h0006);
        wr(4'd4, 16'h0000, 2'b11);
        rd(4'd4, rv);
        chk("R11 status1 cleared", rv, 16'h0000);

        // R12 byte enables and R13 reads without effect
        wr(4'd8, 16'h1234, 2'b01);
        rd(4'd8, rv);
        chk("R12 msg1 low byte", rv, 16'h0034);
        wr(4'd7, 16'hAB00, 2'b10);
        rd(4'd7, rv);
        chk("R12 ctrl2 high byte", rv, 16'hAB08);
        wr(4'd10, 16'h00C3, 2'b00);
        rd(4'd10, rv);
        chk("R12 no byte enable", rv, 16'h0000);
        for (int k = 0; k < 4; k++) rd(4'd2, rv);
        @(negedge clk);
        rd(4'd2, rv);
        chk("R13 read no side effect", rv, 16'h005A);
        rd(4'd4, rv);
        chk("R13 read no status change", rv, 16'h0000);

        // R8 lock, R9 control mask
        wr(4'd6, 16'hFFFF, 2'b11);
        rd(4'd6, rv);
        chk("R9 ctrl1 mask", rv, 16'h1800);
        wr(4'd6, 16'h0000, 2'b11);
        rd(4'd6, rv);
        chk("R8 lock sticky", rv, 16'h1000);
        do_reset();
        rd(4'd6, rv);
        chk("R8 reset clears lock", rv, 16'h0000);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule